// File: doc/BRIEF.md
# Instruction Address Generator

This unit owns the program counter of a simple multi-cycle processor and works out the value the counter takes next. On a cycle where the controller enables an update, the counter takes one of three values. For straight-line code it moves forward by one instruction word. For a taken PC-relative branch it adds a signed byte displacement. For a subroutine return it loads a register value supplied from the operand stage.

Alongside the counter sits a link register. On a call, it keeps the counter value that was current before the update, so that the writeback path can later store it as the return address. A final selector puts one value on the memory address bus. During an instruction fetch that value is the counter. During a load or store it is the ALU result from the execute stage.

The unit is pure datapath plus two registers. It has no state machine, and the controller drives every select line on every cycle. Testing the branch condition and storing instructions are left to other blocks.

Top module: `insn_addr_gen`

## Requirements
- R1: While `rst_n` is low, `pc` and `link_pc` are both 0 after the next clock edge.
- R2: On a clock edge with `pc_upd_en` low, `pc` keeps its value whatever the other inputs do.
- R3: On an edge with `pc_upd_en`=1, `pc_from_ret`=0 and `use_br_ofs`=0, `pc` becomes old `pc` + 4, and `br_ofs` has no effect.
- R4: On an edge with `pc_upd_en`=1, `pc_from_ret`=0 and `use_br_ofs`=1, `pc` becomes old `pc` + `br_ofs`, with `br_ofs` taken as a two's-complement byte displacement.
- R5: On an edge with `pc_upd_en`=1 and `pc_from_ret`=1, `pc` becomes `ret_addr`, and `use_br_ofs` and `br_ofs` have no effect.
- R6: On an edge with `link_en`=1, `link_pc` takes the value `pc` had before that same edge, even when `pc` updates on that edge.
- R7: On an edge with `link_en`=0, `link_pc` keeps its value.
- R8: `mem_addr` equals `pc` when `addr_is_fetch`=1 and equals `alu_addr` when `addr_is_fetch`=0. The path has no register, so `mem_addr` follows a change of its inputs within the same cycle.
- R9: All next-counter sums wrap modulo 2^32. For example, 0xFFFFFFFC + 4 gives 0, and 0 + (-4) gives 0xFFFFFFFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_upd_en | input | 1 | Allows the counter to load its next value |
| pc_from_ret | input | 1 | 1: next counter is `ret_addr`; 0: adder result |
| use_br_ofs | input | 1 | 1: adder adds `br_ofs`; 0: adder adds 4 |
| br_ofs | input | 32 | Signed byte displacement for a branch |
| ret_addr | input | 32 | Return target from the operand register |
| alu_addr | input | 32 | Data address from the ALU result register |
| addr_is_fetch | input | 1 | 1: memory address is the counter; 0: `alu_addr` |
| link_en | input | 1 | Captures the current counter into the link register |
| pc | output | 32 | Current program counter |
| link_pc | output | 32 | Saved counter for call linkage |
| mem_addr | output | 32 | Address presented to memory |

## Verification
The bench steps the counter and compares it with a model built only from the requirements. It targets the points where a wrong design would show itself. With a negative displacement, a design that zero-extends the offset jumps forward instead of back. At the top of the address space, a design that does not wrap leaves the counter stuck or reports a carry. On a return cycle that also requests a branch, a design with the wrong select priority adds the offset instead of loading `ret_addr`. On a call cycle where the counter also advances, a design that reads the next counter would save the post-increment address into the link register. The address selector is checked in both directions with no clock edge between input change and sample, which catches a design that registers `mem_addr`.

// File: rtl/iag_pkg.sv
package iag_pkg;
    parameter int unsigned ADDR_W  = 32;
    parameter int unsigned STEP    = 4;
    parameter int unsigned RST_VEC = 0;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic { SRC_ADDER = 1'b0, SRC_RET = 1'b1 } pc_src_e;
    typedef enum logic { INC_STEP = 1'b0, INC_BRANCH = 1'b1 } inc_src_e;
    typedef enum logic { MA_DATA = 1'b0, MA_FETCH = 1'b1 } ma_src_e;
endpackage

// File: rtl/iag_incr.sv
module iag_incr
    import iag_pkg::*;
#(
    parameter int unsigned W    = ADDR_W,
    parameter int unsigned INCR = STEP
) (
    input  logic [W-1:0] cur,
    input  inc_src_e     inc_sel,
    input  logic [W-1:0] ofs,
    output logic [W-1:0] sum
);
    localparam logic [W-1:0] INCR_V = W'(INCR);
    logic [W-1:0] addend;

    always_comb begin
        unique case (inc_sel)
            INC_STEP:   addend = INCR_V;
            INC_BRANCH: addend = ofs;
            default:    addend = INCR_V;
        endcase
        // Two's-complement add; carry out is dropped so the sum wraps.
        sum = cur + addend;
    end
endmodule

// File: rtl/iag_pc_reg.sv
module iag_pc_reg
    import iag_pkg::*;
#(
    parameter int unsigned W   = ADDR_W,
    parameter int unsigned RST = RST_VEC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd_en,
    input  pc_src_e      src_sel,
    input  logic [W-1:0] adder_val,
    input  logic [W-1:0] ret_val,
    input  logic         lnk_en,
    output logic [W-1:0] pc_q,
    output logic [W-1:0] lnk_q
);
    localparam logic [W-1:0] RST_V = W'(RST);
    logic [W-1:0] pc_d;

    always_comb begin
        unique case (src_sel)
            SRC_ADDER: pc_d = adder_val;
            SRC_RET:   pc_d = ret_val;
            default:   pc_d = adder_val;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RST_V;
        end else if (upd_en) begin
            pc_q <= pc_d;
        end
    end

    // Link register samples the pre-update counter value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lnk_q <= '0;
        end else if (lnk_en) begin
            lnk_q <= pc_q;
        end
    end
endmodule

// File: rtl/iag_addr_mux.sv
module iag_addr_mux
    import iag_pkg::*;
#(
    parameter int unsigned W = ADDR_W
) (
    input  ma_src_e      sel,
    input  logic [W-1:0] fetch_addr,
    input  logic [W-1:0] data_addr,
    output logic [W-1:0] addr
);
    always_comb begin
        unique case (sel)
            MA_FETCH: addr = fetch_addr;
            MA_DATA:  addr = data_addr;
            default:  addr = data_addr;
        endcase
    end
endmodule

// File: rtl/insn_addr_gen.sv
module insn_addr_gen
    import iag_pkg::*;
#(
    parameter int unsigned W = ADDR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pc_upd_en,
    input  logic         pc_from_ret,
    input  logic         use_br_ofs,
    input  logic [W-1:0] br_ofs,
    input  logic [W-1:0] ret_addr,
    input  logic [W-1:0] alu_addr,
    input  logic         addr_is_fetch,
    input  logic         link_en,
    output logic [W-1:0] pc,
    output logic [W-1:0] link_pc,
    output logic [W-1:0] mem_addr
);
    logic [W-1:0] adder_out;
    pc_src_e      src_sel;
    inc_src_e     inc_sel;
    ma_src_e      ma_sel;

    assign src_sel = pc_src_e'(pc_from_ret);
    assign inc_sel = inc_src_e'(use_br_ofs);
    assign ma_sel  = ma_src_e'(addr_is_fetch);

    iag_incr #(.W(W), .INCR(STEP)) u_incr (
        .cur     (pc),
        .inc_sel (inc_sel),
        .ofs     (br_ofs),
        .sum     (adder_out)
    );

    iag_pc_reg #(.W(W), .RST(RST_VEC)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (pc_upd_en),
        .src_sel   (src_sel),
        .adder_val (adder_out),
        .ret_val   (ret_addr),
        .lnk_en    (link_en),
        .pc_q      (pc),
        .lnk_q     (link_pc)
    );

    iag_addr_mux #(.W(W)) u_ma (
        .sel        (ma_sel),
        .fetch_addr (pc),
        .data_addr  (alu_addr),
        .addr       (mem_addr)
    );
endmodule

// File: rtl/insn_addr_gen_chk.sv
module insn_addr_gen_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         pc_upd_en,
    input logic         pc_from_ret,
    input logic         use_br_ofs,
    input logic [W-1:0] br_ofs,
    input logic [W-1:0] ret_addr,
    input logic [W-1:0] alu_addr,
    input logic         addr_is_fetch,
    input logic         link_en,
    input logic [W-1:0] pc,
    input logic [W-1:0] link_pc,
    input logic [W-1:0] mem_addr
);
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && link_pc == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_upd_en |=> $stable(pc));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_upd_en && !pc_from_ret && !use_br_ofs) |=> pc == W'($past(pc) + W'(4)));

    p_branch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_upd_en && !pc_from_ret && use_br_ofs) |=> pc == W'($past(pc) + $past(br_ofs)));

    p_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_upd_en && pc_from_ret) |=> pc == $past(ret_addr));

    p_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
        link_en |=> link_pc == $past(pc));

    p_link_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |=> $stable(link_pc));

    p_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr == (addr_is_fetch ? pc : alu_addr));
endmodule

bind insn_addr_gen insn_addr_gen_chk #(.W(W)) u_chk (.*);

// File: tb/insn_addr_gen_tb.sv
module insn_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pc_upd_en = 1'b0, pc_from_ret = 1'b0, use_br_ofs = 1'b0;
    logic        addr_is_fetch = 1'b1, link_en = 1'b0;
    logic [31:0] br_ofs = '0, ret_addr = '0, alu_addr = '0;
    logic [31:0] pc, link_pc, mem_addr;
    logic [31:0] exp_pc, exp_lnk;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    insn_addr_gen u_dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at falling edge, let one rising edge pass, sample 1 ns later.
    task automatic step(input logic en, input logic ret, input logic br,
                        input logic [31:0] ofs, input logic [31:0] ra, input logic lnk);
        @(negedge clk);
        pc_upd_en = en; pc_from_ret = ret; use_br_ofs = br;
        br_ofs = ofs; ret_addr = ra; link_en = lnk;
        @(posedge clk);
        #1;
        pc_upd_en = 1'b0; link_en = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 pc", pc, 32'h0);
        check("R1 link", link_pc, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        exp_pc = 0; exp_lnk = 0;
    endtask

    task automatic t_seq();
        for (int i = 0; i < 3; i++) begin
            step(1, 0, 0, 32'h0000_7777, 32'hDEAD_BEEF, 0);
            exp_pc = exp_pc + 4;
            check("R3 step", pc, exp_pc);
        end
    endtask

    task automatic t_hold();
        step(0, 1, 1, 32'h40, 32'h1234_5678, 0);
        check("R2 hold", pc, exp_pc);
        step(0, 0, 1, 32'h40, 32'h0, 0);
        check("R2 hold", pc, exp_pc);
    endtask

    task automatic t_branch();
        step(1, 0, 1, 32'h0000_0100, 32'h0, 0);
        exp_pc = exp_pc + 32'h100;
        check("R4 fwd", pc, exp_pc);
        step(1, 0, 1, 32'hFFFF_FFF8, 32'h0, 0);
        exp_pc = exp_pc - 8;
        check("R4 back", pc, exp_pc);
    endtask

    task automatic t_return();
        step(1, 1, 1, 32'h0000_0010, 32'h8000_0000, 0);
        exp_pc = 32'h8000_0000;
        check("R5 ret", pc, exp_pc);
    endtask

    task automatic t_wrap();
        step(1, 1, 0, 32'h0, 32'hFFFF_FFFC, 0);
        step(1, 0, 0, 32'h0, 32'h0, 0);
        check("R9 step wrap", pc, 32'h0);
        step(1, 0, 1, 32'hFFFF_FFFC, 32'h0, 0);
        check("R9 branch wrap", pc, 32'hFFFF_FFFC);
        exp_pc = 32'hFFFF_FFFC;
    endtask

    task automatic t_link();
        step(1, 1, 0, 32'h0, 32'h0000_2000, 0);
        step(1, 0, 0, 32'h0, 32'h0, 1);
        check("R6 link old pc", link_pc, 32'h0000_2000);
        check("R6 pc moved", pc, 32'h0000_2004);
        step(1, 0, 1, 32'h0000_0020, 32'h0, 0);
        check("R7 link hold", link_pc, 32'h0000_2000);
        step(0, 0, 0, 32'h0, 32'h0, 1);
        check("R6 link no update", link_pc, 32'h0000_2024);
        exp_pc = 32'h0000_2024;
    endtask

    task automatic t_addr();
        @(negedge clk);
        alu_addr = 32'h0000_1234; addr_is_fetch = 1'b0;
        #1;
        check("R8 data", mem_addr, 32'h0000_1234);
        addr_is_fetch = 1'b1;
        #1;
        check("R8 fetch", mem_addr, exp_pc);
        alu_addr = 32'hCAFE_0000; addr_is_fetch = 1'b0;
        #1;
        check("R8 data change", mem_addr, 32'hCAFE_0000);
    endtask

    initial begin
        t_reset();
        t_seq();
        t_hold();
        t_branch();
        t_return();
        t_wrap();
        t_link();
        t_addr();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule